// File: doc/BRIEF.md
# Fixed-Off-Time PWM Decay Controller

This block sequences one H-bridge through drive and decay phases to hold a winding current at its chopping threshold. Each PWM cycle starts in drive. For a blanking interval at the start of drive, the controller disregards the digital output of the current comparator. That interval is also the shortest possible drive time. Its length follows the present sine DAC code and the torque scaling setting, so low-current steps get shorter drive pulses.

Once the comparator trips after blanking, the bridge decays for a fixed off-time and then re-enters drive. The off-time is chosen from three values by a tri-level select. The decay type can be slow, fast or mixed. It comes from a pair of tri-level decay selects and from whether the present microstep raises or lowers the current magnitude. In full-step operation the increasing-step choice always applies.

Mixed decay runs fast decay first and slow decay for the rest of the off-time. The fast part is either a percentage of the off-time or one or two blanking intervals. During fast decay, a zero-current flag turns the bridge off so that no reverse current builds up.

All time constants are counted in clock cycles derived from the `CLK_MHZ` parameter. `CLK_MHZ` is expected to be a multiple of 10, so that a 0.3 µs blanking unit is a whole number of cycles. The analog comparison and the gate drivers sit outside this block.

Top module: `pwm_decay_ctrl`

## Requirements
- R1: `bridge_cmd` is encoded as 00 off, 01 drive, 10 slow decay (both low-side switches on) and 11 fast decay (reversed polarity). It reads off during reset, and one cycle after any clock edge that samples `en` low. While `en` stays low the output stays off whatever `trip` does.
- R2: In the cycle after `en` is first sampled high, the bridge drives and a full new blanking interval begins.
- R3: In drive, `trip` is ignored during the first tBLANK cycles. A trip sampled in the last blanking cycle, or any later drive cycle, is accepted. Decay begins in the next cycle, so drive always lasts at least tBLANK cycles.
- R4: tBLANK is a number of 0.1 µs steps times `CLK_MHZ`/10. `sine_code` is 1 to 16. `trq_sel` is 00 = 100 %, 01 = 75 %, 10 = 50 %, 11 = 25 %. For codes 9–16, tBLANK is 1.8, 1.5, 1.5 and 1.2 µs across those four settings in order. For codes 5–8 it is 1.5, 1.5, 1.2 and 0.9 µs. For codes 3–4 it is 1.2, 1.2, 0.9 and 0.9 µs. For codes 1–2 it is 0.9 µs at every setting.
- R5: Every tri-level select uses 00 = low, 01 = high and 1x = floating. With `toff_sel`, low gives 20 µs, high gives 30 µs and floating gives 10 µs. Decay lasts exactly that many cycles (µs × `CLK_MHZ`), then drive resumes. The off-time is taken at the accepted trip.
- R6: The pair {`decay_hi`, `decay_lo`} selects the decay type. Each entry below is written as "increasing step / decreasing step" (`step_dec` = 1 means decreasing):
  - low,low: slow / slow
  - low,high: slow / mixed two-tBLANK
  - high,low: slow / mixed 30 %
  - high,high: mixed 30 % / mixed 30 %
  - low,float: slow / mixed 60 %
  - high,float: slow / fast
  - float,low: mixed one-tBLANK / mixed 30 %
  - float,high: mixed 60 % / mixed 60 %
  - float,float: fast / fast
- R7: Mixed decay shows fast decay first and slow decay for the rest of the off-time. The fast part lasts 30 % or 60 % of the off-time, or one or two tBLANK. Fast decay covers the whole off-time, and slow decay never goes back to fast within one off-time. The type and fast length are taken at the accepted trip.
- R8: With `full_step` = 1, the increasing-step column of R6 is used even when `step_dec` = 1.
- R9: While `zero_cur` = 1, any cycle that would show fast decay shows off instead, and the off-time timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bridge enable; low forces off |
| trip | input | 1 | Digital current comparator output, 1 = threshold reached |
| sine_code | input | 5 | Present sine DAC code, 1 to 16 |
| trq_sel | input | 2 | Torque scaling setting |
| step_dec | input | 1 | 1 = present step lowers the current magnitude |
| zero_cur | input | 1 | 1 = winding current is near zero |
| full_step | input | 1 | 1 = full-step operation |
| decay_hi | input | 2 | Upper tri-level decay select |
| decay_lo | input | 2 | Lower tri-level decay select |
| toff_sel | input | 2 | Tri-level off-time select |
| bridge_cmd | output | 2 | Bridge command |

## Verification
The hardest situations to reach from the ports are decay ends that depend on a length latched at the trip. One is the split of a mixed decay that is measured in blanking intervals. The other is an off-time cut short by a disable, after which a completely fresh blanking interval must follow.

The stimulus reaches these cases in three ways:
- It holds `trip` high from the first drive cycle, so acceptance lands exactly on the last blanking cycle. A separate period raises `trip` only well after blanking, to show late acceptance.
- It walks every decay-select pair through both step directions, and with `full_step` set.
- It drops `en` in the middle of a decay, then re-enables and measures the next blanking interval against its full length.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    BR_OFF   = 2'b00,
    BR_DRIVE = 2'b01,
    BR_SLOW  = 2'b10,
    BR_FAST  = 2'b11
  } bridge_cmd_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_DRIVE,
    PH_DECAY
  } phase_e;

  typedef enum logic [2:0] {
    DK_SLOW,
    DK_FAST,
    DK_MIX30,
    DK_MIX60,
    DK_MIX1B,
    DK_MIX2B
  } decay_kind_e;

  // tri-level select: 00 low, 01 high, 1x floating -> 0,1,2
  function automatic logic [1:0] tri_lvl(logic [1:0] t);
    return t[1] ? 2'd2 : {1'b0, t[0]};
  endfunction

  // blanking length in units of 0.3 us
  function automatic logic [2:0] blank_units(logic [4:0] code, logic [1:0] trq);
    if (code >= 5'd9) begin
      case (trq)
        2'd0:    return 3'd6;
        2'd1,
        2'd2:    return 3'd5;
        default: return 3'd4;
      endcase
    end else if (code >= 5'd5) begin
      case (trq)
        2'd0,
        2'd1:    return 3'd5;
        2'd2:    return 3'd4;
        default: return 3'd3;
      endcase
    end else if (code >= 5'd3) begin
      return trq[1] ? 3'd3 : 3'd4;
    end
    return 3'd3;
  endfunction

  function automatic decay_kind_e pick_decay(logic [1:0] hi, logic [1:0] lo, logic use_dec);
    logic [3:0] key;
    key = {tri_lvl(hi), tri_lvl(lo)};
    case (key)
      4'b00_00: return DK_SLOW;
      4'b00_01: return use_dec ? DK_MIX2B : DK_SLOW;
      4'b01_00: return use_dec ? DK_MIX30 : DK_SLOW;
      4'b01_01: return DK_MIX30;
      4'b00_10: return use_dec ? DK_MIX60 : DK_SLOW;
      4'b01_10: return use_dec ? DK_FAST  : DK_SLOW;
      4'b10_00: return use_dec ? DK_MIX30 : DK_MIX1B;
      4'b10_01: return DK_MIX60;
      4'b10_10: return DK_FAST;
      default:  return DK_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/pdc_timing.sv
module pdc_timing
  import pdc_pkg::*;
#(
  parameter int CLK_MHZ = 20,
  parameter int CW      = 10
) (
  input  logic [4:0]    sine_code,
  input  logic [1:0]    trq_sel,
  input  logic [1:0]    toff_sel,
  output logic [CW-1:0] blank_cyc,
  output logic [CW-1:0] toff_cyc
);
  localparam int UNIT_CYC = (CLK_MHZ * 3) / 10;
  localparam int TOFF_S   = 10 * CLK_MHZ;
  localparam int TOFF_M   = 20 * CLK_MHZ;
  localparam int TOFF_L   = 30 * CLK_MHZ;

  always_comb begin
    blank_cyc = CW'(int'(blank_units(sine_code, trq_sel)) * UNIT_CYC);
    case (tri_lvl(toff_sel))
      2'd0:    toff_cyc = CW'(TOFF_M);
      2'd1:    toff_cyc = CW'(TOFF_L);
      default: toff_cyc = CW'(TOFF_S);
    endcase
  end
endmodule

// File: rtl/pdc_split.sv
module pdc_split
  import pdc_pkg::*;
#(
  parameter int CW = 10
) (
  input  decay_kind_e   kind,
  input  logic [CW-1:0] toff_cyc,
  input  logic [CW-1:0] blank_cyc,
  output logic [CW-1:0] fast_len
);
  always_comb begin
    case (kind)
      DK_FAST:  fast_len = toff_cyc;
      DK_MIX30: fast_len = CW'((32'(toff_cyc) * 3) / 10);
      DK_MIX60: fast_len = CW'((32'(toff_cyc) * 6) / 10);
      DK_MIX1B: fast_len = blank_cyc;
      DK_MIX2B: fast_len = CW'(32'(blank_cyc) * 2);
      default:  fast_len = '0;
    endcase
  end
endmodule

// File: rtl/pdc_phase_fsm.sv
module pdc_phase_fsm
  import pdc_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trip,
  input  logic          zero_cur,
  input  logic [CW-1:0] blank_cyc,
  input  logic [CW-1:0] toff_cyc,
  input  logic [CW-1:0] fast_len,
  output logic [1:0]    bridge_cmd,
  output logic          blank_active,
  output logic          trip_accept,
  output logic          drive_phase,
  output logic          decay_phase,
  output logic [CW-1:0] toff_lat
);
  localparam logic [CW-1:0] ONE = CW'(1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] fast_q;
  logic          decay_end;

  assign drive_phase  = (ph == PH_DRIVE);
  assign decay_phase  = (ph == PH_DECAY);
  assign blank_active = drive_phase && (cnt < blank_cyc - ONE);
  assign trip_accept  = drive_phase && en && trip && !blank_active;
  assign decay_end    = decay_phase && (cnt == toff_lat - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_OFF;
      cnt      <= '0;
      fast_q   <= '0;
      toff_lat <= '0;
    end else if (!en) begin
      ph  <= PH_OFF;
      cnt <= '0;
    end else begin
      case (ph)
        PH_OFF: begin
          ph  <= PH_DRIVE;
          cnt <= '0;
        end
        PH_DRIVE: begin
          if (trip_accept) begin
            ph       <= PH_DECAY;
            cnt      <= '0;
            fast_q   <= fast_len;
            toff_lat <= toff_cyc;
          end else if (blank_active) begin
            cnt <= cnt + ONE;
          end
        end
        PH_DECAY: begin
          if (decay_end) begin
            ph  <= PH_DRIVE;
            cnt <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: ph <= PH_OFF;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_DRIVE: bridge_cmd = BR_DRIVE;
      PH_DECAY: begin
        if (cnt < fast_q) bridge_cmd = zero_cur ? BR_OFF : BR_FAST;
        else              bridge_cmd = BR_SLOW;
      end
      default:  bridge_cmd = BR_OFF;
    endcase
  end
endmodule

// File: rtl/pwm_decay_ctrl.sv
module pwm_decay_ctrl
  import pdc_pkg::*;
#(
  parameter int CLK_MHZ = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trip,
  input  logic [4:0] sine_code,
  input  logic [1:0] trq_sel,
  input  logic       step_dec,
  input  logic       zero_cur,
  input  logic       full_step,
  input  logic [1:0] decay_hi,
  input  logic [1:0] decay_lo,
  input  logic [1:0] toff_sel,
  output logic [1:0] bridge_cmd
);
  localparam int TOFF_MAX = 30 * CLK_MHZ;
  localparam int CW       = $clog2(TOFF_MAX + 1);

  logic [CW-1:0] blank_cyc;
  logic [CW-1:0] toff_cyc;
  logic [CW-1:0] fast_len;
  logic [CW-1:0] toff_lat;
  logic          use_dec;
  decay_kind_e   kind;
  logic          blank_active;
  logic          trip_accept;
  logic          drive_phase;
  logic          decay_phase;

  assign use_dec = step_dec && !full_step;
  assign kind    = pick_decay(decay_hi, decay_lo, use_dec);

  pdc_timing #(.CLK_MHZ(CLK_MHZ), .CW(CW)) u_timing (
    .sine_code (sine_code),
    .trq_sel   (trq_sel),
    .toff_sel  (toff_sel),
    .blank_cyc (blank_cyc),
    .toff_cyc  (toff_cyc)
  );

  pdc_split #(.CW(CW)) u_split (
    .kind      (kind),
    .toff_cyc  (toff_cyc),
    .blank_cyc (blank_cyc),
    .fast_len  (fast_len)
  );

  pdc_phase_fsm #(.CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .trip         (trip),
    .zero_cur     (zero_cur),
    .blank_cyc    (blank_cyc),
    .toff_cyc     (toff_cyc),
    .fast_len     (fast_len),
    .bridge_cmd   (bridge_cmd),
    .blank_active (blank_active),
    .trip_accept  (trip_accept),
    .drive_phase  (drive_phase),
    .decay_phase  (decay_phase),
    .toff_lat     (toff_lat)
  );
endmodule

// File: rtl/pwm_decay_ctrl_chk.sv
module pwm_decay_ctrl_chk
  import pdc_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    bridge_cmd,
  input logic          blank_active,
  input logic          trip_accept,
  input logic          drive_phase,
  input logic          decay_phase,
  input logic [CW-1:0] toff_lat,
  input logic [CW-1:0] blank_cyc
);
  logic [CW-1:0] drv_len;
  logic [CW-1:0] dec_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_len <= '0;
      dec_len <= '0;
    end else begin
      if (drive_phase) begin
        if (drv_len != '1) drv_len <= drv_len + CW'(1);
      end else begin
        drv_len <= '0;
      end
      if (decay_phase) dec_len <= dec_len + CW'(1);
      else             dec_len <= '0;
    end
  end

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> bridge_cmd == BR_OFF);

  assert_drive_after_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |=> bridge_cmd == BR_DRIVE);

  assert_blank_holds_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bridge_cmd == BR_DRIVE && blank_active) |=> bridge_cmd == BR_DRIVE);

  assert_min_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_accept |-> (32'(drv_len) + 1 >= 32'(blank_cyc)));

  assert_decay_follows_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_accept |=> decay_phase);

  assert_decay_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_phase && $past(decay_phase)) |-> dec_len == toff_lat);

  assert_no_fast_after_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_phase && bridge_cmd == BR_SLOW) |=> bridge_cmd != BR_FAST);
endmodule

bind pwm_decay_ctrl pwm_decay_ctrl_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .bridge_cmd   (bridge_cmd),
  .blank_active (blank_active),
  .trip_accept  (trip_accept),
  .drive_phase  (drive_phase),
  .decay_phase  (decay_phase),
  .toff_lat     (toff_lat),
  .blank_cyc    (blank_cyc)
);

// File: tb/pwm_decay_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_decay_ctrl_bench;
  localparam int MHZ = 20;
  localparam logic [1:0] C_OFF = 2'b00, C_DRV = 2'b01, C_SLW = 2'b10, C_FST = 2'b11;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, FL = 2'b10;

  logic clk = 0, rst_n = 0, en = 0, trip = 0, step_dec = 0, zero_cur = 0, full_step = 0;
  logic [4:0] sine_code = 5'd16;
  logic [1:0] trq_sel = 2'b00, decay_hi = LO, decay_lo = LO, toff_sel = FL;
  logic [1:0] bridge_cmd;

  int total = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] cmd;
    string      req;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  always #4 clk = ~clk;

  pwm_decay_ctrl u_pwm_decay_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .sine_code(sine_code),
    .trq_sel(trq_sel), .step_dec(step_dec), .zero_cur(zero_cur), .full_step(full_step),
    .decay_hi(decay_hi), .decay_lo(decay_lo), .toff_sel(toff_sel), .bridge_cmd(bridge_cmd)
  );

  // monitor: compares one expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (bridge_cmd !== cur.cmd) begin
        fails++;
        $display("FAIL %s: bridge_cmd=%b expected %b at %0t", cur.req, bridge_cmd, cur.cmd, $time);
      end
    end
  end

  // blanking in tenths of a microsecond, converted to cycles
  function automatic int exp_blank(int code, int trq);
    int tenths;
    if (code <= 2)      tenths = 9;
    else if (code <= 4) tenths = (trq >= 2) ? 9 : 12;
    else if (code <= 8) tenths = (trq == 3) ? 9 : (trq == 2) ? 12 : 15;
    else                tenths = (trq == 0) ? 18 : (trq == 3) ? 12 : 15;
    return tenths * MHZ / 10;
  endfunction

  function automatic int exp_toff(logic [1:0] sel);
    if (sel[1]) return 10 * MHZ;
    return sel[0] ? 30 * MHZ : 20 * MHZ;
  endfunction

  function automatic logic [1:0] dexp(int j, int fast);
    if (j < fast) return zero_cur ? C_OFF : C_FST;
    return C_SLW;
  endfunction

  task automatic cyc(bit e, bit t, logic [1:0] exp_cmd, string req);
    @(negedge clk);
    #1;
    en   = e;
    trip = t;
    q.push_back('{exp_cmd, req});
  endtask

  // one PWM period from the first drive cycle; abort_at >= 0 drops en in that decay cycle
  task automatic period(int trip_at, int blank, int toff, int fast, int abort_at, string req);
    int  k;
    bit  acc;
    k   = 0;
    acc = 0;
    while (!acc) begin
      bit t;
      t   = (k >= trip_at);
      acc = t && (k >= blank - 1);
      cyc(1, t, acc ? dexp(0, fast) : C_DRV, req);
      k++;
    end
    for (int j = 0; j < toff; j++) begin
      if (j == abort_at) begin
        cyc(0, 0, C_OFF, req);
        return;
      end
      cyc(1, 0, (j + 1 < toff) ? dexp(j + 1, fast) : C_DRV, req);
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : stim
    int b;
    int t;
    repeat (3) @(negedge clk);
    total++;
    if (bridge_cmd !== C_OFF) begin
      fails++;
      $display("FAIL R1 reset: bridge_cmd=%b expected %b", bridge_cmd, C_OFF);
    end
    #1 rst_n = 1;
    cyc(0, 1, C_OFF, "R1 disabled trip ignored");
    cyc(0, 0, C_OFF, "R1 disabled");
    cyc(1, 0, C_DRV, "R2 enable");

    // R3/R4/R5: trip held from drive start, slow decay, floating off-time
    b = exp_blank(16, 0); t = exp_toff(FL);
    period(0, b, t, 0, -1, "R3 R4 R5 code16 trq100");
    // R3: late trip well after blanking
    period(b + 14, b, t, 0, -1, "R3 late trip");

    sine_code = 5'd6; trq_sel = 2'd2; toff_sel = LO;
    period(0, exp_blank(6, 2), exp_toff(LO), 0, -1, "R4 R5 code6 trq50 toff low");
    sine_code = 5'd2; trq_sel = 2'd3; toff_sel = HI;
    period(0, exp_blank(2, 3), exp_toff(HI), 0, -1, "R4 R5 code2 trq25 toff high");
    sine_code = 5'd4; trq_sel = 2'd0; toff_sel = FL;
    period(0, exp_blank(4, 0), exp_toff(FL), 0, -1, "R4 code4 trq100");

    // decay table, code 12 / 75 %
    sine_code = 5'd12; trq_sel = 2'd1;
    b = exp_blank(12, 1); t = exp_toff(FL);
    decay_hi = HI; decay_lo = HI; step_dec = 0;
    period(0, b, t, t * 3 / 10, -1, "R6 R7 high,high inc mixed30");
    decay_hi = LO; decay_lo = HI; step_dec = 1;
    period(0, b, t, 2 * b, -1, "R6 R7 low,high dec mixed two blank");
    decay_hi = LO; decay_lo = HI; step_dec = 0;
    period(0, b, t, 0, -1, "R6 low,high inc slow");
    decay_hi = LO; decay_lo = FL; step_dec = 1;
    period(0, b, t, t * 6 / 10, -1, "R6 R7 low,float dec mixed60");
    decay_hi = HI; decay_lo = LO; step_dec = 1;
    period(0, b, t, t * 3 / 10, -1, "R6 high,low dec mixed30");
    decay_hi = HI; decay_lo = FL; step_dec = 1;
    period(0, b, t, t, -1, "R6 R7 high,float dec fast");
    zero_cur = 1;
    period(0, b, t, t, -1, "R9 zero current during fast");
    zero_cur = 0;
    full_step = 1;
    period(0, b, t, 0, -1, "R8 full step uses increasing column");
    full_step = 0;
    decay_hi = FL; decay_lo = HI; step_dec = 0;
    period(0, b, t, t * 6 / 10, -1, "R6 float,high inc mixed60");
    decay_hi = FL; decay_lo = FL; step_dec = 0;
    period(0, b, t, t, -1, "R6 float,float inc fast");
    decay_hi = FL; decay_lo = LO; step_dec = 1;
    period(0, b, t, t * 3 / 10, -1, "R6 float,low dec mixed30");
    step_dec = 0;
    sine_code = 5'd4; trq_sel = 2'd0; b = exp_blank(4, 0);
    period(0, b, t, b, -1, "R6 R7 float,low inc mixed one blank");
    zero_cur = 1;
    period(0, b, t, b, -1, "R9 zero current in mixed fast part");
    zero_cur = 0;

    // R1/R2: disable inside decay, then fresh blanking
    decay_hi = LO; decay_lo = LO;
    period(0, b, t, 0, 5, "R1 disable mid decay");
    cyc(0, 1, C_OFF, "R1 disabled trip ignored");
    cyc(1, 0, C_DRV, "R2 re-enable");
    period(0, b, t, 0, -1, "R2 fresh blank after re-enable");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule